// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Command Sequencer

This block drives a single DRAM bank. It takes read or write requests, each naming a row and a column. It remembers whether a row is currently held in the bank's row buffer and which row that is. For each request it emits the shortest legal command sequence:

- a lone column command when the requested row is already open;
- activate, then column, when the bank is precharged;
- precharge, activate, then column when a different row is open.

Each accepted request is also reported on one of three one-cycle classification pulses (hit, closed-bank miss, conflict), which are meant for statistics counters.

Three programmable gaps set the minimum spacing between commands:

- activate to column;
- precharge to activate;
- activate to precharge.

Each gap is enforced by its own down-counter, and the command bus shows NOP while a needed counter is still running. A gap value is captured when the command that starts it is issued.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset the bank is precharged with no open row: `req_ready` is 1, the command bus is NOP, no classification pulse is high, and the first request is classified as a closed-bank miss.
- R2: A request to a precharged bank raises `miss_o` in its handshake cycle. ACT appears one cycle later with the request row on `cmd_row`, and the column command follows exactly max(`cfg_act2col`,1) cycles after the ACT.
- R3: A request to the open row raises `hit_o` in its handshake cycle and produces only the column command, one cycle later, with no ACT or PRE.
- R4: A request to a row other than the open one raises `conflict_o` and produces the following sequence:
  - PRE one cycle later, carrying the old row on `cmd_row`;
  - ACT with the new row max(`cfg_pre2act`,1) cycles after the PRE;
  - the column command max(`cfg_act2col`,1) cycles after the ACT.
- R5: PRE closes the open row. After a conflict sequence, the newly activated row is the open row, and a later request to the previous row is again a conflict.
- R6: Command codes on `cmd_o` are NOP=0, ACT=1, RD=2, WR=3, PRE=4.
  - `req_write`=0 yields RD and 1 yields WR.
  - RD and WR carry the request column on `cmd_col`.
- R7: Every cycle of a sequence that issues no command shows NOP on `cmd_o`.
- R8: `req_ready` is high only when no sequence is in progress and all gap counters have expired, and NOP is shown while it is high. For a miss accepted in cycle 0, ready returns in cycle max(2+a, 1+r). For a conflict it returns in cycle max(2+p+a, 1+p+r). For a hit it returns in cycle 2. Here a, p and r are the three gaps with 0 read as 1.
- R9: Exactly one classification pulse is raised for each handshake and none otherwise. A request held valid while `req_ready` is low is not accepted and raises no pulse.
- R10: A gap setting of 0 behaves exactly as a setting of 1, so two commands are never issued in the same or consecutive-zero spacing.
- R11: A precharge never follows an activate sooner than max(`cfg_act2pre`,1) cycles, because the bank does not accept the next request until that gap has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Bank can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W (14) | Requested row |
| req_col | input | COL_W (11) | Requested column |
| cfg_act2col | input | CNT_W (8) | Minimum cycles from ACT to column command |
| cfg_pre2act | input | CNT_W (8) | Minimum cycles from PRE to ACT |
| cfg_act2pre | input | CNT_W (8) | Minimum cycles from ACT to PRE |
| cmd_o | output | 3 | Command code (NOP/ACT/RD/WR/PRE) |
| cmd_row | output | ROW_W (14) | Row field for ACT and PRE |
| cmd_col | output | COL_W (11) | Column field for RD and WR |
| hit_o | output | 1 | Accepted request hit the open row |
| miss_o | output | 1 | Accepted request found the bank precharged |
| conflict_o | output | 1 | Accepted request needs a different row |

## Verification
The following are checked on every cycle:

- the bus is quiet whenever the bank is ready;
- column commands occur only with a row open, and activates only with none;
- each gap holds between the commands it separates, measured by counters in the checker;
- classification pulses are one-hot and tied to a handshake, and each is followed by the right first command.

Only the bench scenarios can show the following:

- the exact cycle of every command and of the return of `req_ready` across a sweep of gap settings, including zero;
- the row and column fields;
- the carry-over of open-row state from one request to the next;
- that a request held during a busy sequence is left unaccepted.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_ACT  = 2'd2,
    ST_COL  = 2'd3
  } st_e;

  typedef enum logic [1:0] {
    CLS_HIT  = 2'd0,
    CLS_MISS = 2'd1,
    CLS_CONF = 2'd2
  } cls_e;

  // Access class from open-row state and row comparison
  function automatic cls_e classify(input logic open_valid, input logic row_match);
    if (!open_valid)   return CLS_MISS;
    else if (row_match) return CLS_HIT;
    else               return CLS_CONF;
  endfunction

endpackage

// File: rtl/dram_gap_cnt.sv
module dram_gap_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] gap,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  // Gap N means the next command may go N cycles later; 0 is read as 1
  function automatic logic [W-1:0] load_value(input logic [W-1:0] g);
    return (g == '0) ? '0 : g - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_value(gap);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dram_open_row.sv
module dram_open_row #(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             open_clr,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_vld,
  output logic [ROW_W-1:0] open_row
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_vld <= 1'b0;
      open_row <= '0;
    end else if (open_set) begin
      open_vld <= 1'b1;
      open_row <= row_in;
    end else if (open_clr) begin
      open_vld <= 1'b0;
    end
  end

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [CNT_W-1:0] cfg_act2col,
  input  logic [CNT_W-1:0] cfg_pre2act,
  input  logic [CNT_W-1:0] cfg_act2pre,
  output logic [2:0]       cmd_o,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             hit_o,
  output logic             miss_o,
  output logic             conflict_o
);

  localparam int CMD_W = $bits(cmd_e);

  st_e              st_q;
  logic [ROW_W-1:0] pend_row;
  logic [COL_W-1:0] pend_col;
  logic             pend_wr;

  logic             open_vld;
  logic [ROW_W-1:0] open_row;
  logic             a2c_done, p2a_done, a2p_done;

  // Named internal events
  logic fire, issue_pre, issue_act, issue_col;
  cls_e cls;
  cmd_e cmd;

  assign req_ready = (st_q == ST_IDLE) && a2c_done && p2a_done && a2p_done;
  assign fire      = req_valid && req_ready;
  assign cls       = classify(open_vld, req_row == open_row);

  assign issue_pre = (st_q == ST_PRE) && a2p_done;
  assign issue_act = (st_q == ST_ACT) && p2a_done;
  assign issue_col = (st_q == ST_COL) && a2c_done;

  always_comb begin
    cmd = CMD_NOP;
    if (issue_pre)      cmd = CMD_PRE;
    else if (issue_act) cmd = CMD_ACT;
    else if (issue_col) cmd = pend_wr ? CMD_WR : CMD_RD;
  end

  assign cmd_o   = CMD_W'(cmd);
  assign cmd_row = issue_act ? pend_row : (issue_pre ? open_row : '0);
  assign cmd_col = issue_col ? pend_col : '0;

  assign hit_o      = fire && (cls == CLS_HIT);
  assign miss_o     = fire && (cls == CLS_MISS);
  assign conflict_o = fire && (cls == CLS_CONF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pend_row <= '0;
      pend_col <= '0;
      pend_wr  <= 1'b0;
    end else begin
      if (fire) begin
        pend_row <= req_row;
        pend_col <= req_col;
        pend_wr  <= req_write;
        unique case (cls)
          CLS_HIT:  st_q <= ST_COL;
          CLS_MISS: st_q <= ST_ACT;
          default:  st_q <= ST_PRE;
        endcase
      end else if (issue_pre) begin
        st_q <= ST_ACT;
      end else if (issue_act) begin
        st_q <= ST_COL;
      end else if (issue_col) begin
        st_q <= ST_IDLE;
      end
    end
  end

  dram_open_row #(.ROW_W(ROW_W)) open_row_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_set (issue_act),
    .open_clr (issue_pre),
    .row_in   (pend_row),
    .open_vld (open_vld),
    .open_row (open_row)
  );

  dram_gap_cnt #(.W(CNT_W)) a2c_i (
    .clk(clk), .rst_n(rst_n), .load(issue_act), .gap(cfg_act2col), .expired(a2c_done)
  );
  dram_gap_cnt #(.W(CNT_W)) p2a_i (
    .clk(clk), .rst_n(rst_n), .load(issue_pre), .gap(cfg_pre2act), .expired(p2a_done)
  );
  dram_gap_cnt #(.W(CNT_W)) a2p_i (
    .clk(clk), .rst_n(rst_n), .load(issue_act), .gap(cfg_act2pre), .expired(a2p_done)
  );

endmodule

// File: rtl/dram_bank_seq_chk.sv
module dram_bank_seq_chk
  import dram_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       cmd,
  input logic             hit,
  input logic             miss,
  input logic             conf,
  input logic             open_vld,
  input logic [CNT_W-1:0] cfg_a2c,
  input logic [CNT_W-1:0] cfg_p2a,
  input logic [CNT_W-1:0] cfg_a2p
);

  localparam logic [CNT_W:0] SAT = '1;

  logic [CNT_W:0] since_act, since_pre;
  logic is_act, is_pre, is_col;

  assign is_act = (cmd == 3'(CMD_ACT));
  assign is_pre = (cmd == 3'(CMD_PRE));
  assign is_col = (cmd == 3'(CMD_RD)) || (cmd == 3'(CMD_WR));

  function automatic logic [CNT_W:0] eff(input logic [CNT_W-1:0] g);
    return (g == '0) ? (CNT_W+1)'(1) : {1'b0, g};
  endfunction

  // Cycles elapsed since the most recent ACT / PRE, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= SAT;
      since_pre <= SAT;
    end else begin
      since_act <= is_act ? (CNT_W+1)'(1) : ((since_act == SAT) ? SAT : since_act + 1'b1);
      since_pre <= is_pre ? (CNT_W+1)'(1) : ((since_pre == SAT) ? SAT : since_pre + 1'b1);
    end
  end

  // R9
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, conf}));

  // R9
  class_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || miss || conf) |-> (req_valid && req_ready));

  // R8
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd == 3'(CMD_NOP)));

  // R3
  hit_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> is_col);

  // R2
  miss_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> is_act);

  // R4
  conf_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conf |=> is_pre);

  // R5
  pre_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> !open_vld);

  // R6
  col_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> open_vld);

  // R2
  act_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !open_vld);

  // R10
  a2c_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (since_act >= eff(cfg_a2c)));

  // R4
  p2a_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_pre >= eff(cfg_p2a)));

  // R11
  a2p_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_act >= eff(cfg_a2p)));

endmodule

bind dram_bank_seq dram_bank_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cmd       (cmd_o),
  .hit       (hit_o),
  .miss      (miss_o),
  .conf      (conflict_o),
  .open_vld  (open_vld),
  .cfg_a2c   (cfg_act2col),
  .cfg_p2a   (cfg_pre2act),
  .cfg_a2p   (cfg_act2pre)
);

// File: tb/dram_bank_seq_tb.sv
`timescale 1ns/1ps
module dram_bank_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [13:0] req_row = '0;
  logic [10:0] req_col = '0;
  logic [7:0]  cfg_act2col = 8'd1, cfg_pre2act = 8'd1, cfg_act2pre = 8'd1;
  logic [2:0]  cmd_o;
  logic [13:0] cmd_row;
  logic [10:0] cmd_col;
  logic        hit_o, miss_o, conflict_o;

  always #2 clk = ~clk;

  dram_bank_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .cfg_act2col(cfg_act2col), .cfg_pre2act(cfg_pre2act), .cfg_act2pre(cfg_act2pre),
    .cmd_o(cmd_o), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .hit_o(hit_o), .miss_o(miss_o), .conflict_o(conflict_o)
  );

  int total = 0;
  int bad = 0;
  bit          m_open = 1'b0;
  logic [13:0] m_row = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] g);
    return (g == 0) ? 1 : int'(g);
  endfunction

  function automatic int imax(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // cls: 0 hit, 1 miss, 2 conflict
  task automatic do_req(input bit wr, input logic [13:0] row, input logic [10:0] col,
                        input bit hold, input bit first);
    int cls, a, p, r, exp_ready, k;
    int e_cmd, e_row, e_col;
    string tag;
    a = eff(cfg_act2col); p = eff(cfg_pre2act); r = eff(cfg_act2pre);
    cls = !m_open ? 1 : (m_row == row) ? 0 : 2;
    tag = (cls == 0) ? "R3" : (cls == 1) ? "R2" : "R4";
    if (first) tag = "R1";
    exp_ready = (cls == 0) ? 2 : (cls == 1) ? imax(2 + a, 1 + r) : imax(2 + p + a, 1 + p + r);

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_row = row; req_col = col;
    #1;
    chk(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
    chk({hit_o, miss_o, conflict_o} == {cls == 0, cls == 1, cls == 2},
        {tag, " R9 class pulse"}, int'({hit_o, miss_o, conflict_o}),
        int'({cls == 0, cls == 1, cls == 2}));
    @(posedge clk);
    #0.5;
    if (hold) begin
      req_row = row ^ 14'h0001; req_col = ~col;
    end else begin
      req_valid = 1'b0;
    end

    k = 1;
    forever begin
      @(negedge clk); #1;
      if (req_ready) break;
      e_cmd = 0; e_row = -1; e_col = -1;
      if (cls == 0) begin
        if (k == 1) begin e_cmd = wr ? 3 : 2; e_col = int'(col); end
      end else if (cls == 1) begin
        if (k == 1) begin e_cmd = 1; e_row = int'(row); end
        else if (k == 1 + a) begin e_cmd = wr ? 3 : 2; e_col = int'(col); end
      end else begin
        if (k == 1) begin e_cmd = 4; e_row = int'(m_row); end
        else if (k == 1 + p) begin e_cmd = 1; e_row = int'(row); end
        else if (k == 1 + p + a) begin e_cmd = wr ? 3 : 2; e_col = int'(col); end
      end
      if (e_cmd == 0)
        chk(int'(cmd_o) == 0, "R7 NOP between commands", int'(cmd_o), 0);
      else
        chk(int'(cmd_o) == e_cmd, {tag, " R6 R10 command code/timing"}, int'(cmd_o), e_cmd);
      if (e_row >= 0) chk(int'(cmd_row) == e_row, {tag, " row field"}, int'(cmd_row), e_row);
      if (e_col >= 0) chk(int'(cmd_col) == e_col, "R6 column field", int'(cmd_col), e_col);
      chk({hit_o, miss_o, conflict_o} == 3'b000, "R9 no pulse while busy",
          int'({hit_o, miss_o, conflict_o}), 0);
      k++;
      if (k > 300) break;
    end
    chk(k == exp_ready, "R8 R11 ready return cycle", k, exp_ready);
    req_valid = 1'b0;
    m_open = 1'b1;
    m_row  = row;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] vals [4];
    logic [13:0] ra, rb;
    int idx;
    vals[0] = 8'd0; vals[1] = 8'd1; vals[2] = 8'd2; vals[3] = 8'd4;
    repeat (4) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(int'(cmd_o) == 0, "R1 NOP after reset", int'(cmd_o), 0);
    chk({hit_o, miss_o, conflict_o} == 3'b000, "R1 no pulse after reset",
        int'({hit_o, miss_o, conflict_o}), 0);

    idx = 0;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        for (int m = 0; m < 4; m++) begin
          cfg_act2col = vals[i]; cfg_pre2act = vals[j]; cfg_act2pre = vals[m];
          repeat (10) @(posedge clk);
          ra = 14'((idx * 517 + 3) & 16'h3fff);
          rb = ra ^ 14'h2aaa;
          do_req(1'b0, ra, 11'(idx * 13), 1'b0, idx == 0);
          do_req(1'b1, ra, 11'(idx * 7 + 1), 1'b0, 1'b0);
          do_req(1'b0, rb, 11'(idx), 1'b1, 1'b0);
          do_req(1'b1, rb, 11'h7ff, 1'b0, 1'b0);
          // R5: the previous row must now be a conflict again
          do_req(1'b0, ra, 11'h000, 1'b0, 1'b0);
          idx++;
        end
      end
    end
    cfg_act2col = 8'd3; cfg_pre2act = 8'd2; cfg_act2pre = 8'd6;
    repeat (10) @(posedge clk);
    do_req(1'b1, 14'h3fff, 11'h7ff, 1'b0, 1'b0);
    do_req(1'b0, 14'h3fff, 11'h400, 1'b1, 1'b0);
    do_req(1'b0, 14'h0000, 11'h001, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule